// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block gives software control of 64 or 96 general-purpose pins over a simple 32-bit register bus. Each pin can be an input or an output. Output values change only through two write-one registers, one that raises bits and one that lowers them, so two agents can touch different pins without a read-modify-write race. Every pad input passes through a two-stage synchroniser before software or the edge logic sees it.

Each pin can flag a rising edge, a falling edge or both into a sticky status bit. Software clears a status bit by writing a one to it. A combined interrupt line stays high while any status bit is set. The registers are grouped by feature. Every feature takes one 32-bit word per group of 32 pins, and the feature groups follow one another in a fixed order. The bus is a single-cycle write strobe plus a read path that depends only on the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input, every output value is 0, both edge enables are 0 for every pin, every status bit is 0, every in-range word reads 0 while the pads are low, and `irq` is 0.
- R2: Let W = NUM_PINS/32. A word has byte address `kind*W*4 + (pin/32)*4`, and the pin sits at bit `pin%32` of that word. The kind codes are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status. Direction and both enable words are written whole and read back what was written.
- R3: A write to a set word raises the output value of every pin whose data bit is 1, and leaves the other pins unchanged. Both the set word and the clear word read back the current output values.
- R4: A write to a clear word lowers the output value of every pin whose data bit is 1, and leaves the other pins unchanged.
- R5: `pad_oe` bit n equals direction bit n (1 = output). `pad_out` bit n equals the output value of pin n.
- R6: A level word reads the pad input after two clock edges of synchronisation, whatever the pin's direction. A write to a level word changes nothing.
- R7: A 0-to-1 change of a synchronised input sets that pin's status bit when the pin's rising enable is 1. The bit is visible three clock edges after the pad changes.
- R8: A 1-to-0 change sets the status bit when the falling enable is 1. With both enables set, both kinds of edge are caught. An edge whose enable is 0 sets nothing.
- R9: Writing a 1 to a status bit clears it. Status bits written with 0 keep their value.
- R10: If a qualifying edge and a write-one clear reach the same status bit at the same clock edge, the bit ends up set.
- R11: `irq` is 1 exactly when at least one status bit is 1.
- R12: Word addresses above the last status word read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Output value to each pad driver |
| pad_oe | output | NUM_PINS | Output enable for each pad driver |
| irq | output | 1 | High while any edge status bit is set |

## Verification
The hardest case to reach from the ports is the collision in R10, where a write-one clear lands on a status bit at the same clock edge as a new qualifying edge. The bench brings this about by counting registers. It first leaves a status bit set through a both-edge enable. It then moves the pad, waits two rising edges for the synchroniser to present the edge, and issues the clear so that it lands on the third edge. A design in which the clear wins would read the bit back as 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int WORD_W     = 32;
   localparam int KIND_COUNT = 7;

   typedef enum logic [2:0] {
      KIND_LEVEL = 3'd0,
      KIND_DIR   = 3'd1,
      KIND_SET   = 3'd2,
      KIND_CLR   = 3'd3,
      KIND_RISE  = 3'd4,
      KIND_FALL  = 3'd5,
      KIND_STAT  = 3'd6
   } kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] lvl_q,
   output logic [NUM_PINS-1:0] rise_ev,
   output logic [NUM_PINS-1:0] fall_ev
);
   logic [NUM_PINS-1:0] meta_q;
   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         lvl_q  <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= pad_in;
         lvl_q  <= meta_q;
         prev_q <= lvl_q;
      end
   end

   assign rise_ev = lvl_q & ~prev_q;
   assign fall_ev = ~lvl_q & prev_q;
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 64,
   localparam int WPF     = NUM_PINS / WORD_W,
   localparam int BANK_W  = (WPF > 1) ? $clog2(WPF) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  kind_e               wr_kind,
   input  logic [BANK_W-1:0]   wr_bank,
   input  logic [WORD_W-1:0]   wdata,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] out_q,
   output logic [NUM_PINS-1:0] rise_en_q,
   output logic [NUM_PINS-1:0] fall_en_q
);
   for (genvar b = 0; b < WPF; b++) begin : g_bank
      logic sel;
      assign sel = wr_en && (wr_bank == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_q[b*WORD_W +: WORD_W]     <= '0;
            out_q[b*WORD_W +: WORD_W]     <= '0;
            rise_en_q[b*WORD_W +: WORD_W] <= '0;
            fall_en_q[b*WORD_W +: WORD_W] <= '0;
         end else if (sel) begin
            case (wr_kind)
               KIND_DIR:  dir_q[b*WORD_W +: WORD_W]     <= wdata;
               KIND_SET:  out_q[b*WORD_W +: WORD_W]     <= out_q[b*WORD_W +: WORD_W] | wdata;
               KIND_CLR:  out_q[b*WORD_W +: WORD_W]     <= out_q[b*WORD_W +: WORD_W] & ~wdata;
               KIND_RISE: rise_en_q[b*WORD_W +: WORD_W] <= wdata;
               KIND_FALL: fall_en_q[b*WORD_W +: WORD_W] <= wdata;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 64,
   localparam int WPF     = NUM_PINS / WORD_W,
   localparam int BANK_W  = (WPF > 1) ? $clog2(WPF) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  kind_e               wr_kind,
   input  logic [BANK_W-1:0]   wr_bank,
   input  logic [WORD_W-1:0]   wdata,
   input  logic [NUM_PINS-1:0] rise_ev,
   input  logic [NUM_PINS-1:0] fall_ev,
   input  logic [NUM_PINS-1:0] rise_en,
   input  logic [NUM_PINS-1:0] fall_en,
   output logic [NUM_PINS-1:0] stat_q
);
   logic [NUM_PINS-1:0] hit;
   assign hit = (rise_ev & rise_en) | (fall_ev & fall_en);

   for (genvar b = 0; b < WPF; b++) begin : g_bank
      logic [WORD_W-1:0] clr_mask;
      assign clr_mask = (wr_en && wr_kind == KIND_STAT && wr_bank == BANK_W'(b)) ? wdata : '0;

      // a new edge is ORed in after the clear mask, so it survives a coincident clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q[b*WORD_W +: WORD_W] <= '0;
         else        stat_q[b*WORD_W +: WORD_W] <= (stat_q[b*WORD_W +: WORD_W] & ~clr_mask)
                                                   | hit[b*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 64,
   localparam int WPF     = NUM_PINS / WORD_W,
   localparam int BANK_W  = (WPF > 1) ? $clog2(WPF) : 1,
   localparam int ADDR_W  = $clog2(KIND_COUNT * WPF * 4),
   localparam int WIDX_W  = ADDR_W - 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);
   if (NUM_PINS != 64 && NUM_PINS != 96) begin : g_bad_pins
      $error("gpio_bank_ctrl: NUM_PINS must be 64 or 96");
   end

   logic [WIDX_W-1:0]   widx;
   logic                acc_hit;
   kind_e               acc_kind;
   logic [BANK_W-1:0]   acc_bank;
   logic                wr_en;
   logic [NUM_PINS-1:0] lvl_q, rise_ev, fall_ev;
   logic [NUM_PINS-1:0] dir_q, out_q, rise_en_q, fall_en_q, stat_q;

   assign widx = bus_addr[ADDR_W-1:2];

   always_comb begin
      acc_hit  = (int'(widx) < KIND_COUNT * WPF);
      acc_kind = kind_e'(3'(int'(widx) / WPF));
      acc_bank = BANK_W'(int'(widx) % WPF);
   end

   assign wr_en = bus_wr && acc_hit;

   gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
      .lvl_q(lvl_q), .rise_ev(rise_ev), .fall_ev(fall_ev)
   );

   gpio_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(acc_kind),
      .wr_bank(acc_bank), .wdata(bus_wdata),
      .dir_q(dir_q), .out_q(out_q), .rise_en_q(rise_en_q), .fall_en_q(fall_en_q)
   );

   gpio_edge_status #(.NUM_PINS(NUM_PINS)) u_stat (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(acc_kind),
      .wr_bank(acc_bank), .wdata(bus_wdata),
      .rise_ev(rise_ev), .fall_ev(fall_ev), .rise_en(rise_en_q), .fall_en(fall_en_q),
      .stat_q(stat_q)
   );

   logic [WPF-1:0][WORD_W-1:0] lvl_w, dir_w, out_w, ren_w, fen_w, st_w;
   assign lvl_w = lvl_q;
   assign dir_w = dir_q;
   assign out_w = out_q;
   assign ren_w = rise_en_q;
   assign fen_w = fall_en_q;
   assign st_w  = stat_q;

   always_comb begin
      bus_rdata = '0;
      if (acc_hit) begin
         case (acc_kind)
            KIND_LEVEL:        bus_rdata = lvl_w[acc_bank];
            KIND_DIR:          bus_rdata = dir_w[acc_bank];
            KIND_SET, KIND_CLR: bus_rdata = out_w[acc_bank];
            KIND_RISE:         bus_rdata = ren_w[acc_bank];
            KIND_FALL:         bus_rdata = fen_w[acc_bank];
            KIND_STAT:         bus_rdata = st_w[acc_bank];
            default:           bus_rdata = '0;
         endcase
      end
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q;
   assign irq     = |stat_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 64,
   parameter int BANK_W   = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input kind_e               wr_kind,
   input logic [BANK_W-1:0]   wr_bank,
   input logic [WORD_W-1:0]   wdata,
   input logic [NUM_PINS-1:0] dir_q,
   input logic [NUM_PINS-1:0] out_q,
   input logic [NUM_PINS-1:0] rise_ev,
   input logic [NUM_PINS-1:0] fall_ev,
   input logic [NUM_PINS-1:0] rise_en,
   input logic [NUM_PINS-1:0] fall_en,
   input logic [NUM_PINS-1:0] stat_q,
   input logic                irq
);
   // R3
   set_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == KIND_SET && wr_bank == '0)
      |=> ((out_q[WORD_W-1:0] & $past(wdata)) == $past(wdata)));

   // R4
   clr_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == KIND_CLR && wr_bank == '0)
      |=> ((out_q[WORD_W-1:0] & $past(wdata)) == '0));

   // R6
   level_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == KIND_LEVEL)
      |=> ($stable(out_q) && $stable(dir_q) && $stable(rise_en) && $stable(fall_en)));

   // R7
   rise_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_ev[0] && rise_en[0]) |=> stat_q[0]);

   // R8
   fall_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_ev[0] && fall_en[0]) |=> stat_q[0]);

   // R9
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[0] && !(wr_en && wr_kind == KIND_STAT && wr_bank == '0 && wdata[0]))
      |=> stat_q[0]);

   // R11
   irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (stat_q != '0));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(acc_kind), .wr_bank(acc_bank),
   .wdata(bus_wdata), .dir_q(dir_q), .out_q(out_q), .rise_ev(rise_ev), .fall_ev(fall_ev),
   .rise_en(rise_en_q), .fall_en(fall_en_q), .stat_q(stat_q), .irq(irq)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
   localparam int NP = 64;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpio_bank_ctrl #(.NUM_PINS(NP)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // byte address for kind k, bank b with two words per feature (R2)
   function automatic logic [AW-1:0] adr(int k, int b);
      return AW'(k * 8 + b * 4);
   endfunction

   function automatic string req_of(int k);
      case (k)
         2: return "R3";
         3: return "R4";
         1: return "R5";
         default: return "R2";
      endcase
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic wait_edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // entry: {rd, kind[2:0], bank[1:0], data[31:0]}; reads compare with data
   localparam int NV = 17;
   localparam logic [37:0] VEC [0:NV-1] = '{
      {1'b0, 3'd2, 2'd0, 32'h0000_00F0},   // set bits 7:4 (R3)
      {1'b1, 3'd2, 2'd0, 32'h0000_00F0},
      {1'b1, 3'd3, 2'd0, 32'h0000_00F0},   // clear word reads outputs (R3)
      {1'b0, 3'd2, 2'd0, 32'h0F00_0000},
      {1'b1, 3'd2, 2'd0, 32'h0F00_00F0},
      {1'b0, 3'd3, 2'd0, 32'h0000_0030},   // clear bits 5:4 (R4)
      {1'b1, 3'd3, 2'd0, 32'h0F00_00C0},
      {1'b1, 3'd2, 2'd1, 32'h0000_0000},   // bank 1 untouched (R2)
      {1'b0, 3'd1, 2'd1, 32'hA5A5_0000},   // direction bank 1 (R5)
      {1'b1, 3'd1, 2'd1, 32'hA5A5_0000},
      {1'b1, 3'd1, 2'd0, 32'h0000_0000},
      {1'b0, 3'd0, 2'd0, 32'hFFFF_FFFF},   // level write ignored (R6)
      {1'b1, 3'd2, 2'd0, 32'h0F00_00C0},
      {1'b0, 3'd4, 2'd1, 32'h0000_0001},   // rising enable pin 32
      {1'b1, 3'd4, 2'd1, 32'h0000_0001},
      {1'b0, 3'd5, 2'd0, 32'h8000_0000},   // falling enable pin 31
      {1'b1, 3'd5, 2'd0, 32'h8000_0000}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int k = 0; k < 7; k++)
         for (int b = 0; b < 2; b++) begin
            bus_read(adr(k, b), rd);
            check("R1", 64'(rd), 64'h0);
         end
      check("R1 irq", 64'(irq), 64'h0);
      check("R1 oe", pad_oe, 64'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][37]) begin
            bus_read(adr(int'(VEC[i][36:34]), int'(VEC[i][33:32])), rd);
            check(req_of(int'(VEC[i][36:34])), 64'(rd), 64'(VEC[i][31:0]));
         end else begin
            bus_write(adr(int'(VEC[i][36:34]), int'(VEC[i][33:32])), VEC[i][31:0]);
         end
      end

      // R5: pad drivers follow direction and output values
      check("R5 oe", pad_oe, 64'hA5A5_0000_0000_0000);
      check("R5 out", pad_out, 64'h0000_0000_0F00_00C0);

      // R6: level sync latency and independence from direction
      pad_in[5] = 1'b1; pad_in[40] = 1'b1; pad_in[48] = 1'b1;
      wait_edges(1);
      bus_read(adr(0, 0), rd);
      check("R6 one edge", 64'(rd), 64'h0);
      wait_edges(1);
      bus_read(adr(0, 0), rd);
      check("R6 bank0", 64'(rd), 64'h20);
      bus_read(adr(0, 1), rd);
      check("R6 bank1", 64'(rd), 64'h0001_0100);
      wait_edges(2);

      // R8: edges without enables set nothing
      bus_read(adr(6, 0), rd);
      check("R8 no enable", 64'(rd), 64'h0);
      bus_read(adr(6, 1), rd);
      check("R8 no enable b1", 64'(rd), 64'h0);

      // R7 / R11: rising edge on pin 32
      pad_in[32] = 1'b1;
      wait_edges(2);
      bus_read(adr(6, 1), rd);
      check("R7 not yet", 64'(rd), 64'h0);
      wait_edges(1);
      bus_read(adr(6, 1), rd);
      check("R7 rise", 64'(rd), 64'h1);
      check("R11 irq high", 64'(irq), 64'h1);

      // R9: write zero keeps, write one clears
      bus_write(adr(6, 1), 32'h0);
      bus_read(adr(6, 1), rd);
      check("R9 zero keeps", 64'(rd), 64'h1);
      bus_write(adr(6, 1), 32'h1);
      bus_read(adr(6, 1), rd);
      check("R9 one clears", 64'(rd), 64'h0);
      check("R11 irq low", 64'(irq), 64'h0);

      // R8: pin 31 rises (no rise enable) then falls (fall enabled)
      pad_in[31] = 1'b1;
      wait_edges(4);
      bus_read(adr(6, 0), rd);
      check("R8 rise ignored", 64'(rd), 64'h0);
      pad_in[31] = 1'b0;
      wait_edges(3);
      bus_read(adr(6, 0), rd);
      check("R8 fall", 64'(rd), 64'h8000_0000);
      bus_write(adr(6, 0), 32'h8000_0000);
      bus_write(adr(4, 0), 32'h8000_0000);
      pad_in[31] = 1'b1;
      wait_edges(3);
      bus_read(adr(6, 0), rd);
      check("R8 both edges", 64'(rd), 64'h8000_0000);

      // R10: clear lands on the same edge as a new falling edge
      pad_in[31] = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      bus_write(adr(6, 0), 32'h8000_0000);
      bus_read(adr(6, 0), rd);
      check("R10 set wins", 64'(rd), 64'h8000_0000);
      bus_write(adr(6, 0), 32'h8000_0000);
      bus_read(adr(6, 0), rd);
      check("R10 later clear", 64'(rd), 64'h0);
      check("R11 irq after clear", 64'(irq), 64'h0);

      // R12: out-of-range words
      bus_write(AW'(56), 32'hFFFF_FFFF);
      bus_write(AW'(60), 32'hFFFF_FFFF);
      bus_read(AW'(56), rd);
      check("R12 read 56", 64'(rd), 64'h0);
      bus_read(AW'(60), rd);
      check("R12 read 60", 64'(rd), 64'h0);
      bus_read(adr(1, 0), rd);
      check("R12 dir intact", 64'(rd), 64'h0);
      bus_read(adr(2, 0), rd);
      check("R12 out intact", 64'(rd), 64'h0F00_00C0);
      bus_read(adr(4, 1), rd);
      check("R12 enable intact", 64'(rd), 64'h1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule